// File: doc/BRIEF.md
# Track Window-Cut Decision Unit

This block takes one candidate track per cycle and produces a small vector of trigger decision bits. Each track has a signed curvature, a signed dip slope, a signed z0, an unsigned z0 error, a found-segment count and a one-bit class. Each decision bit has two sets of eight programmable cuts, one set per track class. A decision bit is set only when the track passes every cut in the set that matches its class.

One of the eight cuts limits the number of missing segments. The block folds the curvature and dip into an index and reads a 4-bit maximum possible segment count from a lookup memory. It subtracts the found count from that maximum, clamping at zero, and compares the result with the cut.

A host writes both the cut registers and the lookup memory through a plain address/data/write-enable port. The result appears one clock after the track, qualified by a valid strobe.

Top module: `trk_cut_unit`

## Requirements
- R1: After reset, `dec_vld` and `dec_bits` are 0 and every cut register holds 0. With zeroed cuts, every window is empty, so a track gives all decision bits 0.
- R2: The cut for decision bit n (0..3), class c (0/1) and kind k (0..7) sits at address 0x100*(n+1) + 0x10*c + k. The kinds are: 0 curvature low, 1 curvature high, 2 dip low, 3 dip high, 4 z0 low, 5 z0 high, 6 z0-error limit, 7 missing-segment limit. Each cut is 8 bits wide.
- R3: The curvature, dip and z0 cuts pass only when low < value < high, compared as signed two's complement. A value equal to either bound fails.
- R4: The z0-error cut passes only when z0 error < limit, compared as unsigned.
- R5: A write to 0x1000..0x1FFF stores `cfg_wdata[3:0]` into lookup entry `cfg_addr[11:0]`.
- R6: The lookup index for a track is {a[6:2], dip[7:1]}, where a is the absolute curvature and a curvature of -128 is taken as 127.
- R7: Missing segments equal the lookup value minus `trk_segs`, clamped at 0. The missing-segment cut passes only when this count < limit, compared as unsigned.
- R8: A track with `trk_cls`=0 is judged by the class-0 cuts, and one with `trk_cls`=1 by the class-1 cuts.
- R9: `dec_bits[n]` is the AND of all eight cut results for bit n.
- R10: `dec_vld` is high exactly one cycle after `trk_vld`, carrying that track's `dec_bits`. When `dec_vld` is low, `dec_bits` is 0.
- R11: A cut or lookup write in the same cycle as a track does not affect that track. It applies from the next track on.
- R12: Writes to unmapped addresses change nothing. Examples: 0x0108, 0x0120, 0x0500, 0x0000, and any address at 0x2000 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_addr | input | 16 | Host write address |
| cfg_wdata | input | 8 | Host write data |
| trk_vld | input | 1 | Track present this cycle |
| trk_cls | input | 1 | Track class, selects the cut set |
| trk_curv | input | 8 | Signed curvature |
| trk_dip | input | 8 | Signed dip slope |
| trk_z0 | input | 8 | Signed z0 |
| trk_z0err | input | 8 | Unsigned z0 error |
| trk_segs | input | 4 | Found-segment count |
| dec_vld | output | 1 | Decision vector valid |
| dec_bits | output | 4 | Decision bits, one per cut set |

## Verification
A host write and a track evaluation can land in the same cycle. The write can target a cut register of the track's own set, or the exact lookup entry the track reads. The bench drives both on one edge and computes the expected bits from its model before applying the write. It then repeats the same track on the next cycle and expects the new value to govern. Random tracks with occasional colliding cut writes, together with a patterned lookup table, repeat this collision many times.

// File: rtl/trk_cut_pkg.sv
package trk_cut_pkg;
   localparam int N_CLS  = 2;
   localparam int N_KIND = 8;

   typedef enum int {
      CK_CURV_LO  = 0,
      CK_CURV_HI  = 1,
      CK_DIP_LO   = 2,
      CK_DIP_HI   = 3,
      CK_Z0_LO    = 4,
      CK_Z0_HI    = 5,
      CK_Z0ERR_HI = 6,
      CK_MISS_HI  = 7
   } cut_kind_e;
endpackage

// File: rtl/trk_cut_regs.sv
module trk_cut_regs
   import trk_cut_pkg::*;
#(
   parameter int N_DEC  = 4,
   parameter int CUT_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          cfg_we,
   input  logic [ADDR_W-1:0]                             cfg_addr,
   input  logic [CUT_W-1:0]                              cfg_wdata,
   output logic [N_DEC-1:0][N_CLS-1:0][N_KIND-1:0][CUT_W-1:0] cuts
);
   localparam int HI_W = ADDR_W - 12;

   logic [3:0] blk;
   logic       hit;

   assign blk = cfg_addr[11:8];
   assign hit = cfg_we && (cfg_addr[ADDR_W-1:12] == '0) && (blk != 4'd0)
                && (int'(blk) <= N_DEC) && (cfg_addr[7:5] == 3'd0) && !cfg_addr[3];

   for (genvar n = 0; n < N_DEC; n++) begin : g_dec
      for (genvar c = 0; c < N_CLS; c++) begin : g_cls
         for (genvar k = 0; k < N_KIND; k++) begin : g_kind
            logic             sel;
            logic [CUT_W-1:0] q;
            assign sel = hit && (blk == 4'(n + 1)) && (cfg_addr[4] == 1'(c))
                         && (cfg_addr[2:0] == 3'(k));
            always_ff @(posedge clk) begin
               if (!rst_n)   q <= '0;
               else if (sel) q <= cfg_wdata;
            end
            assign cuts[n][c][k] = q;

            // R2
            cut_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
               cfg_we && (cfg_addr == ADDR_W'((n + 1) * 256 + c * 16 + k))
               |=> q == $past(cfg_wdata));
         end
      end
   end

   logic map_ok;
   always_comb map_ok = (cfg_addr >= ADDR_W'(256)) && (cfg_addr < ADDR_W'((N_DEC + 1) * 256))
                        && ((cfg_addr & ADDR_W'('hE8)) == '0);

   // R12
   unmapped_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we && !map_ok |=> $stable(cuts));

   logic [HI_W-1:0] unused_hi;
   assign unused_hi = '0;
endmodule

// File: rtl/trk_seg_lut.sv
module trk_seg_lut #(
   parameter int SEG_W  = 4,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [SEG_W-1:0]  cfg_wdata,
   input  logic              rd_en,
   input  logic [7:0]        rd_curv,
   input  logic [6:0]        rd_dip_hi,
   output logic [SEG_W-1:0]  rd_q
);
   localparam int IDX_W = 12;
   localparam int DEPTH = 1 << IDX_W;
   localparam int HI_W  = ADDR_W - IDX_W;

   logic [SEG_W-1:0] mem [DEPTH];
   logic             wr;
   logic [7:0]       abs_curv;
   logic [IDX_W-1:0] rd_idx;

   assign wr = cfg_we && (cfg_addr[ADDR_W-1:IDX_W] == HI_W'(1));

   always_comb begin
      if (rd_curv == 8'h80)  abs_curv = 8'd127;
      else if (rd_curv[7])   abs_curv = 8'(-rd_curv);
      else                   abs_curv = rd_curv;
   end

   assign rd_idx = {abs_curv[6:2], rd_dip_hi};

   always_ff @(posedge clk) begin
      if (wr)    mem[cfg_addr[IDX_W-1:0]] <= cfg_wdata;
      if (rd_en) rd_q <= mem[rd_idx];
   end
endmodule

// File: rtl/trk_cut_eval.sv
module trk_cut_eval
   import trk_cut_pkg::*;
#(
   parameter int N_DEC = 4,
   parameter int CUT_W = 8,
   parameter int SEG_W = 4
) (
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic                                          trk_vld,
   input  logic                                          trk_cls,
   input  logic [CUT_W-1:0]                              trk_curv,
   input  logic [CUT_W-1:0]                              trk_dip,
   input  logic [CUT_W-1:0]                              trk_z0,
   input  logic [CUT_W-1:0]                              trk_z0err,
   input  logic [SEG_W-1:0]                              trk_segs,
   input  logic [N_DEC-1:0][N_CLS-1:0][N_KIND-1:0][CUT_W-1:0] cuts,
   input  logic [SEG_W-1:0]                              lut_q,
   output logic                                          dec_vld,
   output logic [N_DEC-1:0]                              dec_bits
);
   function automatic logic inside_open(input logic [CUT_W-1:0] v,
                                        input logic [CUT_W-1:0] lo,
                                        input logic [CUT_W-1:0] hi);
      return ($signed(lo) < $signed(v)) && ($signed(v) < $signed(hi));
   endfunction

   logic             vld_r;
   logic [SEG_W-1:0] segs_r;
   logic [SEG_W-1:0] miss;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_r  <= 1'b0;
         segs_r <= '0;
      end else begin
         vld_r <= trk_vld;
         if (trk_vld) segs_r <= trk_segs;
      end
   end

   always_comb miss = (lut_q > segs_r) ? SEG_W'(lut_q - segs_r) : '0;

   for (genvar n = 0; n < N_DEC; n++) begin : g_bit
      logic [N_KIND-1:0][CUT_W-1:0] cs;
      logic                         win;
      logic                         win_q;
      logic [CUT_W-1:0]             mcut_q;

      assign cs  = cuts[n][trk_cls];
      assign win = inside_open(trk_curv, cs[CK_CURV_LO], cs[CK_CURV_HI])
                && inside_open(trk_dip,  cs[CK_DIP_LO],  cs[CK_DIP_HI])
                && inside_open(trk_z0,   cs[CK_Z0_LO],   cs[CK_Z0_HI])
                && (trk_z0err < cs[CK_Z0ERR_HI]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_q  <= 1'b0;
            mcut_q <= '0;
         end else if (trk_vld) begin
            win_q  <= win;
            mcut_q <= cs[CK_MISS_HI];
         end
      end

      assign dec_bits[n] = vld_r && win_q && (CUT_W'(miss) < mcut_q);
   end

   assign dec_vld = vld_r;
endmodule

// File: rtl/trk_cut_unit.sv
module trk_cut_unit
   import trk_cut_pkg::*;
#(
   parameter int N_DEC  = 4,
   parameter int CUT_W  = 8,
   parameter int SEG_W  = 4,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [CUT_W-1:0]  cfg_wdata,
   input  logic              trk_vld,
   input  logic              trk_cls,
   input  logic [CUT_W-1:0]  trk_curv,
   input  logic [CUT_W-1:0]  trk_dip,
   input  logic [CUT_W-1:0]  trk_z0,
   input  logic [CUT_W-1:0]  trk_z0err,
   input  logic [SEG_W-1:0]  trk_segs,
   output logic              dec_vld,
   output logic [N_DEC-1:0]  dec_bits
);
   if (CUT_W != 8)                 begin : g_chk_w   $error("CUT_W must be 8");               end
   if (N_DEC < 1 || N_DEC > 15)    begin : g_chk_n   $error("N_DEC out of range 1..15");      end
   if (SEG_W < 1 || SEG_W > CUT_W) begin : g_chk_s   $error("SEG_W out of range");            end
   if (ADDR_W < 13)                begin : g_chk_a   $error("ADDR_W too narrow for the map"); end

   logic [N_DEC-1:0][N_CLS-1:0][N_KIND-1:0][CUT_W-1:0] cuts;
   logic [SEG_W-1:0] lut_q;

   trk_cut_regs #(.N_DEC(N_DEC), .CUT_W(CUT_W), .ADDR_W(ADDR_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cuts(cuts));

   trk_seg_lut #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) lut_i (
      .clk(clk), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata[SEG_W-1:0]), .rd_en(trk_vld),
      .rd_curv(trk_curv), .rd_dip_hi(trk_dip[7:1]), .rd_q(lut_q));

   trk_cut_eval #(.N_DEC(N_DEC), .CUT_W(CUT_W), .SEG_W(SEG_W)) eval_i (
      .clk(clk), .rst_n(rst_n), .trk_vld(trk_vld), .trk_cls(trk_cls),
      .trk_curv(trk_curv), .trk_dip(trk_dip), .trk_z0(trk_z0),
      .trk_z0err(trk_z0err), .trk_segs(trk_segs), .cuts(cuts),
      .lut_q(lut_q), .dec_vld(dec_vld), .dec_bits(dec_bits));

   // R10
   vld_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trk_vld |=> dec_vld);
   // R10
   vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trk_vld |=> !dec_vld && (dec_bits == '0));

   for (genvar n = 0; n < N_DEC; n++) begin : g_chk
      // R3
      curv_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_vld && dec_bits[n] && !$past(trk_cls)
         |-> ($signed($past(cuts[n][0][CK_CURV_LO])) < $signed($past(trk_curv)))
          && ($signed($past(trk_curv)) < $signed($past(cuts[n][0][CK_CURV_HI]))));
      // R4
      z0err_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dec_vld && dec_bits[n] && $past(trk_cls)
         |-> $past(trk_z0err) < $past(cuts[n][1][CK_Z0ERR_HI]));
   end
endmodule

// File: tb/trk_cut_unit_tb_top.sv
module trk_cut_unit_tb_top;
   localparam int CLK_PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [15:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       trk_vld = 1'b0;
   logic       trk_cls = 1'b0;
   logic [7:0] trk_curv = '0, trk_dip = '0, trk_z0 = '0, trk_z0err = '0;
   logic [3:0] trk_segs = '0;
   logic       dec_vld;
   logic [3:0] dec_bits;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] m_cut [4][2][8];
   logic [3:0] m_lut [4096];
   logic [3:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_PER/2) clk = ~clk;

   trk_cut_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .trk_vld(trk_vld), .trk_cls(trk_cls),
      .trk_curv(trk_curv), .trk_dip(trk_dip), .trk_z0(trk_z0),
      .trk_z0err(trk_z0err), .trk_segs(trk_segs),
      .dec_vld(dec_vld), .dec_bits(dec_bits));

   function automatic logic [15:0] caddr(int n, int c, int k);
      return 16'((n + 1) * 256 + c * 16 + k);
   endfunction

   function automatic int sv8(logic [7:0] v);
      return int'($signed(v));
   endfunction

   // R3 R4 R6 R7 R8 R9: independent model of one decision vector
   function automatic logic [3:0] calc(bit cls, logic [7:0] cv, logic [7:0] dp,
                                       logic [7:0] z, logic [7:0] ze, logic [3:0] sg);
      int acv, av, mx, miss;
      logic [11:0] idx;
      logic [3:0] r;
      acv = sv8(cv);
      av  = (acv < 0) ? -acv : acv;
      if (acv == -128) av = 127;
      idx  = {5'(av >> 2), dp[7:1]};
      mx   = int'(m_lut[idx]);
      miss = (mx > int'(sg)) ? mx - int'(sg) : 0;
      for (int n = 0; n < 4; n++) begin
         r[n] = (sv8(m_cut[n][cls][0]) < acv) && (acv < sv8(m_cut[n][cls][1]))
             && (sv8(m_cut[n][cls][2]) < sv8(dp)) && (sv8(dp) < sv8(m_cut[n][cls][3]))
             && (sv8(m_cut[n][cls][4]) < sv8(z)) && (sv8(z) < sv8(m_cut[n][cls][5]))
             && (ze < m_cut[n][cls][6]) && (miss < int'(m_cut[n][cls][7]));
      end
      return r;
   endfunction

   // R2 R5 R12: model of the write decode
   task automatic model_wr(logic [15:0] a, logic [7:0] d);
      if (a[15:12] == 4'h1) m_lut[a[11:0]] = d[3:0];
      else if (a[15:12] == 4'h0 && a[11:8] >= 4'd1 && a[11:8] <= 4'd4
               && a[7:5] == 3'd0 && !a[3])
         m_cut[int'(a[11:8]) - 1][a[4]][a[2:0]] = d;
   endtask

   // driver: one cycle of stimulus; expected value taken before the write lands (R11)
   task automatic step(bit w, logic [15:0] a, logic [7:0] d, bit t, bit cls,
                       logic [7:0] cv, logic [7:0] dp, logic [7:0] z,
                       logic [7:0] ze, logic [3:0] sg, string tag);
      @(negedge clk);
      cfg_we = w; cfg_addr = a; cfg_wdata = d;
      trk_vld = t; trk_cls = cls; trk_curv = cv; trk_dip = dp;
      trk_z0 = z; trk_z0err = ze; trk_segs = sg;
      if (t) begin
         exp_q.push_back(calc(cls, cv, dp, z, ze, sg));
         tag_q.push_back(tag);
      end
      if (w) model_wr(a, d);
   endtask

   task automatic idle();
      step(0, '0, '0, 0, 0, '0, '0, '0, '0, '0, "");
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] d);
      step(1, a, d, 0, 0, '0, '0, '0, '0, '0, "");
   endtask

   task automatic trk(bit cls, logic [7:0] cv, logic [7:0] dp, logic [7:0] z,
                      logic [7:0] ze, logic [3:0] sg, string tag);
      step(0, '0, '0, 1, cls, cv, dp, z, ze, sg, tag);
   endtask

   task automatic prog(int n, int c, int lo_c, int hi_c, int lo_d, int hi_d,
                       int lo_z, int hi_z, int zelim, int mlim);
      wr(caddr(n, c, 0), 8'(lo_c)); wr(caddr(n, c, 1), 8'(hi_c));
      wr(caddr(n, c, 2), 8'(lo_d)); wr(caddr(n, c, 3), 8'(hi_d));
      wr(caddr(n, c, 4), 8'(lo_z)); wr(caddr(n, c, 5), 8'(hi_z));
      wr(caddr(n, c, 6), 8'(zelim)); wr(caddr(n, c, 7), 8'(mlim));
   endtask

   task automatic expect_bits(logic [3:0] e, string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor / scoreboard
   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         if (dec_vld) begin
            checks++;
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL R10: dec_vld=1 with no track outstanding, bits=%b expected none", dec_bits);
            end else begin
               automatic logic [3:0] e = exp_q.pop_front();
               automatic string tg = tag_q.pop_front();
               if (dec_bits !== e) begin
                  errors++;
                  $display("FAIL %s: dec_bits=%b expected %b", tg, dec_bits, e);
               end
            end
         end else if (dec_bits !== 4'b0) begin
            checks++; errors++;
            $display("FAIL R10: dec_bits=%b while dec_vld low, expected 0000", dec_bits);
         end
      end
   end

   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         done = 1;
         errors++; checks++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      for (int n = 0; n < 4; n++)
         for (int c = 0; c < 2; c++)
            for (int k = 0; k < 8; k++) m_cut[n][c][k] = '0;
      for (int i = 0; i < 4096; i++) m_lut[i] = '0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state at the ports
      checks++;
      if (dec_vld !== 1'b0 || dec_bits !== 4'b0) begin
         errors++;
         $display("FAIL R1: vld=%b bits=%b expected 0 0000", dec_vld, dec_bits);
      end

      // R5: fill the lookup with a pattern so any wrong index shows
      for (int i = 0; i < 4096; i++)
         wr(16'(4096 + i), 8'((i * 5 + (i >> 6) * 3 + 1) & 15));

      // R1: zeroed cuts reject every track
      trk(0, 8'd0, 8'd0, 8'd0, 8'd0, 4'd15, "R1");
      trk(1, 8'd1, 8'd1, 8'd1, 8'd0, 4'd15, "R1");

      // R2: program cut sets
      prog(0, 0, -50, 50, -60, 60, -20, 20, 30, 3);
      prog(1, 0, 0, 100, -128, 127, -128, 127, 255, 15);
      prog(2, 0, -100, -10, -128, 127, -128, 127, 255, 15);
      prog(3, 0, -50, 50, -60, 60, -20, 20, 30, 1);
      prog(0, 1, -10, 10, -10, 10, -5, 5, 10, 2);
      prog(2, 1, -128, 127, -128, 127, -128, 127, 200, 16);
      prog(3, 1, -128, 127, -128, 127, -128, 127, 200, 1);

      // R9 R2: main function, several patterns
      trk(0, 8'd20, 8'd10, 8'd0, 8'd5, 4'd7, "R9");
      expect_bits(4'b0000, ""); exp_q.pop_back(); tag_q.pop_back();
      trk(0, 8'(-30), 8'(-5), 8'(3), 8'd29, 4'd2, "R9");
      trk(0, 8'd60, 8'd0, 8'd0, 8'd0, 4'd0, "R2");
      // R3: equal to bound fails, one inside passes
      trk(0, 8'd50, 8'd0, 8'd0, 8'd0, 4'd15, "R3");
      trk(0, 8'd49, 8'd0, 8'd0, 8'd0, 4'd15, "R3");
      trk(0, 8'(-50), 8'd0, 8'd0, 8'd0, 4'd15, "R3");
      trk(0, 8'd0, 8'd60, 8'd0, 8'd0, 4'd15, "R3");
      trk(0, 8'd0, 8'd0, 8'(-20), 8'd0, 4'd15, "R3");
      trk(0, 8'd0, 8'd0, 8'd19, 8'd0, 4'd15, "R3");
      // R4: unsigned z0 error limit, equality fails
      trk(0, 8'd1, 8'd1, 8'd1, 8'd30, 4'd15, "R4");
      trk(0, 8'd1, 8'd1, 8'd1, 8'd200, 4'd15, "R4");
      trk(1, 8'd1, 8'd1, 8'd1, 8'd9, 4'd15, "R4");
      trk(1, 8'd1, 8'd1, 8'd1, 8'd10, 4'd15, "R4");
      // R8: same values, both classes
      trk(0, 8'd5, 8'd5, 8'd2, 8'd3, 4'd15, "R8");
      trk(1, 8'd5, 8'd5, 8'd2, 8'd3, 4'd15, "R8");
      // R6 R7: fold and missing-segment arithmetic
      trk(1, 8'd127, 8'd100, 8'd0, 8'd0, 4'd0, "R6");
      trk(1, 8'(-127), 8'(-1), 8'd0, 8'd0, 4'd3, "R6");
      trk(1, 8'(-4), 8'(-128), 8'd0, 8'd0, 4'd1, "R6");
      trk(1, 8'd3, 8'd77, 8'd0, 8'd0, 4'd2, "R6");
      trk(1, 8'(-128), 8'd10, 8'd0, 8'd0, 4'd4, "R6");
      trk(0, 8'd2, 8'd2, 8'd0, 8'd0, 4'd15, "R7");
      trk(0, 8'd2, 8'd2, 8'd0, 8'd0, 4'd0, "R7");
      wr(16'h1000 | {5'd0, 7'd1}, 8'd9);
      trk(1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd8, "R7");
      trk(1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd9, "R7");
      trk(1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd10, "R7");
      idle();

      // R11: write colliding with a track, then the same track again
      step(1, caddr(0, 0, 1), 8'd5, 1, 0, 8'd20, 8'd0, 8'd0, 8'd0, 4'd15, "R11");
      trk(0, 8'd20, 8'd0, 8'd0, 8'd0, 4'd15, "R11");
      step(1, 16'h1000 | {5'd0, 7'd1}, 8'd15, 1, 1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd9, "R11");
      trk(1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd9, "R11");
      wr(caddr(0, 0, 1), 8'd50);
      idle();

      // R12: unmapped writes that would alias under sloppy decode
      wr(16'h0108, 8'h7F);
      wr(16'h0120, 8'h7F);
      wr(16'h0500, 8'h7F);
      wr(16'h0000, 8'h7F);
      wr(16'h2000 | {5'd0, 7'd1}, 8'h00);
      wr(16'h0109, 8'h00);
      trk(0, 8'd2, 8'd2, 8'd0, 8'd0, 4'd15, "R12");
      trk(0, 8'd2, 8'd2, 8'd0, 8'd0, 4'd13, "R12");
      trk(1, 8'd2, 8'd2, 8'd0, 8'd0, 4'd0, "R12");

      // R10 R11: back-to-back random tracks with occasional colliding cut writes
      for (int i = 0; i < 400; i++) begin
         automatic bit w = ($urandom % 8) == 0;
         automatic logic [15:0] a = caddr($urandom % 4, $urandom % 2, $urandom % 8);
         automatic logic [7:0] d = 8'($urandom);
         automatic bit t = ($urandom % 4) != 0;
         step(w, a, d, t, 1'($urandom), 8'($signed(8'($urandom)) >>> 1),
              8'($signed(8'($urandom)) >>> 1), 8'($signed(8'($urandom)) >>> 2),
              8'($urandom % 40), 4'($urandom), "R10");
      end
      repeat (4) idle();

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule